// File: doc/BRIEF.md
# Windowed Two-Key Deadman Timer

This block supervises software by counting clock cycles while it runs. If software does not clear it in time, it raises a timeout event and pulses a reset request. A clear takes two ordered writes. First an arming word goes to one register. Then a kick word goes to a second register. The kick counts only once the live count has reached a programmed window point inside the period. A kick that comes too early, a wrong word, or a kick that was never armed sets its own sticky error flag. Each such error also raises the event at once.

Software reaches the block through a small memory-mapped request port. A request is taken in any cycle where `req_valid` and `req_ready` are both high. Writes produce no response. A read returns its data with `rsp_valid` one cycle after it is taken. The block drops `req_ready` for exactly one cycle after the timer is switched off. A request held valid in that cycle is not taken and must be presented again. The period and the window point are parameters, and the window point must be below the period. Two read-only registers expose both values.

Register map (byte offsets): run control 0x00, arming word 0x10, kick word 0x20, status 0x30, live count 0x40, reset cause 0x50, period 0x60, window point 0x70. Reads of the arming, kick and any unmapped offset return zero.

Top module: `deadman_timer`

## Requirements
- R1: After reset, the status, live count, control and reset-cause registers read zero, `rst_req` is low and `req_ready` is high.
- R2: Bit 15 of the control register (0x00) runs the timer. While it is 0, the live count (0x40) reads 0. While it is 1, the count rises by one per clock, so the first read taken in the cycle after the enabling write returns 0.
- R3: Status bit 0 (0x30) reads 1 exactly when the live count is at or above the window point WINDOW.
- R4: Writing 0x0000_4000 to 0x10 arms the sequence. A later write of 0x0000_0008 to 0x20, taken while status bit 0 is 1, resets the live count to 0 and disarms the sequence, so a second kick needs a fresh arming write.
- R5: With the timer running, a write to 0x10 of any word other than 0x0000_4000, or a write to 0x20 while unarmed, sets sticky status bit 7.
- R6: With the timer armed, a write to 0x20 of any word other than 0x0000_0008, or of the right word while status bit 0 is 0, sets sticky status bit 6.
- R7: If the timer runs PERIOD cycles after enabling with no accepted kick, sticky status bit 5 sets, `rst_req` is high for exactly one cycle in the cycle after the PERIOD-th counting edge, and the count restarts from 0.
- R8: Any error of R5 or R6 also sets status bit 5 and pulses `rst_req` for one cycle right after the offending write.
- R9: Every event sets bit 5 of the reset-cause register (0x50). Writing a word with bit 5 set clears it; writing a word with bit 5 clear leaves it unchanged.
- R10: In the cycle after a write clears control bit 15 on a running timer, `req_ready` is low and a request offered then is not taken.
- R11: Offsets 0x60 and 0x70 read PERIOD and WINDOW, and `rsp_valid` is high in the cycle after a read is taken.
- R12: While the timer is stopped, writes to 0x10 and 0x20 change no status bit and raise no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Register request offered |
| req_ready | output | 1 | Request can be taken this cycle |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | 8 | Byte offset of the register |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| rst_req | output | 1 | One-cycle reset request on each event |

## Verification
The hardest case to reach is a kick that lands in exactly the first cycle where the window is open, or one cycle before it. The outcome changes there between a clean clear and a second-key error. The bench resets the block for each trial and enables it. It writes the arming word on the next cycle, then waits a chosen number of idle cycles before the kick. It sweeps that wait across the whole period, so every kick position from the first cycle up to just before expiry is tried once. The expected status, count and reset cause follow arithmetically from the kick position.

// File: rtl/dmt_pkg.sv
package dmt_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] OFS_CTRL   = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_ARM    = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_KICK   = 8'h20;
  localparam logic [ADDR_W-1:0] OFS_STAT   = 8'h30;
  localparam logic [ADDR_W-1:0] OFS_CNT    = 8'h40;
  localparam logic [ADDR_W-1:0] OFS_RCAUSE = 8'h50;
  localparam logic [ADDR_W-1:0] OFS_PERIOD = 8'h60;
  localparam logic [ADDR_W-1:0] OFS_WIN    = 8'h70;

  localparam logic [DATA_W-1:0] ARM_WORD  = 32'h0000_4000;
  localparam logic [DATA_W-1:0] KICK_WORD = 32'h0000_0008;

  localparam int BIT_RUN   = 15;
  localparam int BIT_WIN   = 0;
  localparam int BIT_EVT   = 5;
  localparam int BIT_ERR2  = 6;
  localparam int BIT_ERR1  = 7;
  localparam int BIT_CAUSE = 5;

  typedef struct packed {
    logic err1;
    logic err2;
    logic evt;
    logic win;
  } stat_t;
endpackage

// File: rtl/dmt_counter.sv
module dmt_counter #(
  parameter int PERIOD = 1000,
  parameter int WINDOW = 600,
  parameter int CNT_W  = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             kick_ok,
  output logic [CNT_W-1:0] cnt_q,
  output logic             win_open,
  output logic             expire
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);
  localparam logic [CNT_W-1:0] WPT  = CNT_W'(WINDOW);

  assign expire   = run && (cnt_q == LAST) && !kick_ok;
  assign win_open = (cnt_q >= WPT);

  always_ff @(posedge clk) begin
    if (!rst_n)                      cnt_q <= '0;
    else if (!run || kick_ok || expire) cnt_q <= '0;
    else                             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/dmt_keyseq.sv
module dmt_keyseq (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic arm_wr,
  input  logic arm_match,
  input  logic kick_wr,
  input  logic kick_match,
  input  logic win_open,
  input  logic expire,
  output logic kick_ok,
  output logic bad_first,
  output logic bad_second
);
  logic armed_q;

  assign bad_first  = run && ((arm_wr && !arm_match) || (kick_wr && !armed_q));
  assign bad_second = run && kick_wr && armed_q && (!kick_match || !win_open);
  assign kick_ok    = run && kick_wr && armed_q && kick_match && win_open;

  always_ff @(posedge clk) begin
    if (!rst_n)                armed_q <= 1'b0;
    else if (!run || expire)   armed_q <= 1'b0;
    else if (kick_wr)          armed_q <= 1'b0;
    else if (arm_wr)           armed_q <= arm_match;
  end
endmodule

// File: rtl/dmt_status.sv
module dmt_status (
  input  logic clk,
  input  logic rst_n,
  input  logic bad_first,
  input  logic bad_second,
  input  logic expire,
  input  logic cause_clr,
  output logic err1_q,
  output logic err2_q,
  output logic evt_q,
  output logic cause_q,
  output logic rst_req_q
);
  logic fire;
  assign fire = bad_first || bad_second || expire;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err1_q    <= 1'b0;
      err2_q    <= 1'b0;
      evt_q     <= 1'b0;
      cause_q   <= 1'b0;
      rst_req_q <= 1'b0;
    end else begin
      if (bad_first)  err1_q <= 1'b1;
      if (bad_second) err2_q <= 1'b1;
      if (fire)       evt_q  <= 1'b1;
      if (fire)           cause_q <= 1'b1;
      else if (cause_clr) cause_q <= 1'b0;
      rst_req_q <= fire;
    end
  end
endmodule

// File: rtl/dmt_regif.sv
module dmt_regif
  import dmt_pkg::*;
#(
  parameter int PERIOD = 1000,
  parameter int WINDOW = 600,
  parameter int CNT_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic [CNT_W-1:0]  cnt,
  input  stat_t             stat,
  input  logic              cause,
  output logic              run_q,
  output logic              arm_wr,
  output logic              arm_match,
  output logic              kick_wr,
  output logic              kick_match,
  output logic              cause_clr
);
  logic blk_q, take, wr, rd;
  logic [DATA_W-1:0] rmux;

  assign req_ready  = !blk_q;
  assign take       = req_valid && req_ready;
  assign wr         = take && req_write;
  assign rd         = take && !req_write;
  assign arm_wr     = wr && (req_addr == OFS_ARM);
  assign kick_wr    = wr && (req_addr == OFS_KICK);
  assign arm_match  = (req_wdata == ARM_WORD);
  assign kick_match = (req_wdata == KICK_WORD);
  assign cause_clr  = wr && (req_addr == OFS_RCAUSE) && req_wdata[BIT_CAUSE];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      blk_q <= 1'b0;
    end else begin
      blk_q <= wr && (req_addr == OFS_CTRL) && run_q && !req_wdata[BIT_RUN];
      if (wr && (req_addr == OFS_CTRL)) run_q <= req_wdata[BIT_RUN];
    end
  end

  always_comb begin
    rmux = '0;
    case (req_addr)
      OFS_CTRL:   rmux[BIT_RUN] = run_q;
      OFS_STAT: begin
        rmux[BIT_ERR1] = stat.err1;
        rmux[BIT_ERR2] = stat.err2;
        rmux[BIT_EVT]  = stat.evt;
        rmux[BIT_WIN]  = stat.win;
      end
      OFS_CNT:    rmux = DATA_W'(cnt);
      OFS_RCAUSE: rmux[BIT_CAUSE] = cause;
      OFS_PERIOD: rmux = DATA_W'(PERIOD);
      OFS_WIN:    rmux = DATA_W'(WINDOW);
      default:    rmux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd;
      if (rd) rsp_rdata <= rmux;
    end
  end
endmodule

// File: rtl/deadman_timer.sv
module deadman_timer #(
  parameter int PERIOD = 1000,
  parameter int WINDOW = 600
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic        req_write,
  input  logic [7:0]  req_addr,
  input  logic [31:0] req_wdata,
  output logic        rsp_valid,
  output logic [31:0] rsp_rdata,
  output logic        rst_req
);
  import dmt_pkg::*;
  localparam int CNT_W = $clog2(PERIOD + 1);

  logic             run_q, arm_wr, arm_match, kick_wr, kick_match, cause_clr;
  logic             kick_ok, bad_first, bad_second, win_open, expire;
  logic             err1_q, err2_q, evt_q, cause_q;
  logic [CNT_W-1:0] cnt_q;
  stat_t            stat;

  assign stat = '{err1: err1_q, err2: err2_q, evt: evt_q, win: win_open};

  dmt_regif #(.PERIOD(PERIOD), .WINDOW(WINDOW), .CNT_W(CNT_W)) u_regif (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .cnt(cnt_q), .stat(stat), .cause(cause_q),
    .run_q(run_q), .arm_wr(arm_wr), .arm_match(arm_match),
    .kick_wr(kick_wr), .kick_match(kick_match), .cause_clr(cause_clr)
  );

  dmt_counter #(.PERIOD(PERIOD), .WINDOW(WINDOW), .CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(run_q), .kick_ok(kick_ok),
    .cnt_q(cnt_q), .win_open(win_open), .expire(expire)
  );

  dmt_keyseq u_keys (
    .clk(clk), .rst_n(rst_n), .run(run_q),
    .arm_wr(arm_wr), .arm_match(arm_match),
    .kick_wr(kick_wr), .kick_match(kick_match),
    .win_open(win_open), .expire(expire),
    .kick_ok(kick_ok), .bad_first(bad_first), .bad_second(bad_second)
  );

  dmt_status u_stat (
    .clk(clk), .rst_n(rst_n),
    .bad_first(bad_first), .bad_second(bad_second), .expire(expire),
    .cause_clr(cause_clr),
    .err1_q(err1_q), .err2_q(err2_q), .evt_q(evt_q), .cause_q(cause_q),
    .rst_req_q(rst_req)
  );
endmodule

// File: rtl/deadman_timer_chk.sv
module deadman_timer_chk #(
  parameter int PERIOD = 1000,
  parameter int CNT_W  = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             req_write,
  input logic             rsp_valid,
  input logic             rst_req,
  input logic             run_q,
  input logic [CNT_W-1:0] cnt_q,
  input logic             evt_q,
  input logic             cause_q
);
  p_cnt_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |=> (cnt_q == '0));

  p_cnt_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CNT_W'(PERIOD));

  p_req_evt_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> evt_q);

  p_evt_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    evt_q |=> evt_q);

  p_req_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> cause_q);

  p_stall_after_stop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(run_q) |-> !req_ready);

  p_read_rsp_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_write) |=> rsp_valid);
endmodule

bind deadman_timer deadman_timer_chk #(.PERIOD(PERIOD), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .rsp_valid(rsp_valid), .rst_req(rst_req),
  .run_q(run_q), .cnt_q(cnt_q), .evt_q(evt_q), .cause_q(cause_q)
);

// File: tb/tb_deadman_timer.sv
module tb_deadman_timer;
  localparam int P = 40;
  localparam int W = 24;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write;
  logic [7:0]  req_addr;
  logic [31:0] req_wdata;
  logic        req_ready, rsp_valid, rst_req;
  logic [31:0] rsp_rdata;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  deadman_timer #(.PERIOD(P), .WINDOW(W)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rst_req(rst_req)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d, output logic v);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    d = rsp_rdata; v = rsp_valid;
    req_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    idle(2);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic v;
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    @(negedge clk);
    do_reset();

    // R1 reset state
    chk("R1 ready", {31'b0, req_ready}, 1);
    chk("R1 rst_req", {31'b0, rst_req}, 0);
    rd(8'h30, d, v); chk("R1 status", d, 0);
    rd(8'h40, d, v); chk("R1 count", d, 0);
    rd(8'h00, d, v); chk("R1 control", d, 0);
    rd(8'h50, d, v); chk("R1 cause", d, 0);

    // R11 read-only period and window, response timing
    rd(8'h60, d, v); chk("R11 period", d, P); chk("R11 rsp_valid", {31'b0, v}, 1);
    rd(8'h70, d, v); chk("R11 window", d, W);

    // R2 count held at zero while stopped
    idle(5);
    rd(8'h40, d, v); chk("R2 count stopped", d, 0);

    // R12 keys ignored while stopped
    wr(8'h10, 32'h1234);
    chk("R12 no rst_req", {31'b0, rst_req}, 0);
    wr(8'h20, 32'h8);
    rd(8'h30, d, v); chk("R12 status", d, 0);

    // R2 counting, R3 window sweep
    do_reset();
    wr(8'h00, 32'h8000);
    for (int j = 1; j < P; j++) begin
      rd(8'h30, d, v);
      chk("R3 window flag", {31'b0, d[0]}, ((j - 1) >= W) ? 1 : 0);
    end
    do_reset();
    wr(8'h00, 32'h8000);
    rd(8'h40, d, v); chk("R2 first count", d, 0);
    rd(8'h40, d, v); chk("R2 second count", d, 1);
    idle(10);
    rd(8'h40, d, v); chk("R2 later count", d, 12);

    // R7 expiry
    do_reset();
    wr(8'h00, 32'h8000);
    begin
      int hit = 0;
      for (int i = 1; i <= 2 * P; i++) begin
        @(negedge clk);
        if (rst_req && hit == 0) hit = i;
        if (hit != 0) break;
      end
      chk("R7 expiry cycle", hit, P);
    end
    idle(1);
    chk("R7 pulse width", {31'b0, rst_req}, 0);
    rd(8'h30, d, v); chk("R7 status", d, 32'h20);
    rd(8'h40, d, v); chk("R7 restart count", d, 2);

    // R9 reset cause
    rd(8'h50, d, v); chk("R9 cause set", d, 32'h20);
    wr(8'h50, 32'h0);
    rd(8'h50, d, v); chk("R9 cause kept", d, 32'h20);
    wr(8'h50, 32'h20);
    rd(8'h50, d, v); chk("R9 cause cleared", d, 0);

    // R5 wrong arming word; R8 immediate event
    do_reset();
    wr(8'h00, 32'h8000);
    wr(8'h10, 32'h4100);
    chk("R8 rst_req after error", {31'b0, rst_req}, 1);
    idle(1);
    chk("R8 rst_req one cycle", {31'b0, rst_req}, 0);
    rd(8'h30, d, v); chk("R5 bad arm status", d, 32'hA0);

    // R5 kick without arming
    do_reset();
    wr(8'h00, 32'h8000);
    wr(8'h20, 32'h8);
    rd(8'h30, d, v); chk("R5 unarmed kick", d, 32'hA0);

    // R6 wrong kick word inside window
    do_reset();
    wr(8'h00, 32'h8000);
    wr(8'h10, 32'h4000);
    idle(25);
    wr(8'h20, 32'h9);
    rd(8'h30, d, v); chk("R6 wrong kick", d, 32'h61);

    // R4 disarm after a good kick
    do_reset();
    wr(8'h00, 32'h8000);
    wr(8'h10, 32'h4000);
    idle(25);
    wr(8'h20, 32'h8);
    wr(8'h20, 32'h8);
    rd(8'h30, d, v); chk("R4 re-arm needed", d, 32'hA0);

    // R4 / R6 kick position sweep (kick taken m edges after enable)
    for (int k = 0; k <= P - 3; k++) begin
      int m;
      m = k + 2;
      do_reset();
      wr(8'h00, 32'h8000);
      wr(8'h10, 32'h4000);
      idle(k);
      wr(8'h20, 32'h8);
      rd(8'h30, d, v);
      if (m >= W + 1) chk("R4 clean kick status", d, 0);
      else            chk("R6 early kick status", d, 32'h60 | ((m >= W) ? 1 : 0));
      rd(8'h40, d, v);
      chk("R4 count after kick", d, (m >= W + 1) ? 1 : m + 1);
      rd(8'h50, d, v);
      chk("R9 cause after kick", d, (m >= W + 1) ? 0 : 32'h20);
    end

    // R10 stall after stopping
    do_reset();
    wr(8'h00, 32'h8000);
    idle(5);
    wr(8'h00, 32'h0);
    chk("R10 ready low", {31'b0, req_ready}, 0);
    wr(8'h00, 32'h8000);
    chk("R10 ready back", {31'b0, req_ready}, 1);
    rd(8'h00, d, v); chk("R10 stalled write dropped", d, 0);
    rd(8'h40, d, v); chk("R2 count cleared on stop", d, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule